// File: doc/BRIEF.md
# SRAM Window Bridge

This block is one slice of a register bank. It claims a window of the register address space, but the words in that window are not stored in the bank's own flip-flops. Each host access that hits the window becomes an access to an external synchronous SRAM. The SRAM has one cycle of read latency, and the bridge drives its address, write data and per-byte write enables.

The host side is a plain request/acknowledge bus. A single-cycle valid strobe carries a read/write flag, a byte address, 32-bit write data and four byte strobes. The bridge answers with a one-cycle done pulse and 32-bit read data. The window holds DEPTH words of 32 bits, and each word takes four bytes of address space starting at BASE_ADDR.

A parameter fixes the access mode: read-write, read-only or write-only. In write-only mode the bus can only load the memory, and the user logic reads it through its own port, for example to use a lookup table that software fills. A request that the mode forbids still completes, but the SRAM is not touched. The host issues a new request only when no read is in flight. A request that arrives during a read sequence is dropped.

Top module: `sram_window_bridge`

## Requirements
- R1: A byte address A is claimed when BASE_ADDR <= A < BASE_ADDR + 4*DEPTH. The element index is (A - BASE_ADDR) >> 2, so the two low address bits have no effect. With the defaults (BASE_ADDR 0x100, DEPTH 16) the last element is at 0x13C.
- R2: An unclaimed request produces no req_done pulse, and mem_wen stays 0.
- R3: A permitted write that is requested in cycle t shows mem_addr = index, mem_wdata = req_wdata and mem_wen = req_strb in cycle t+1. Bit b of mem_wen enables data bits 8b+7..8b. mem_wen is zero again in t+2 unless another write follows. req_done is high in cycle t+1.
- R4: A permitted read requested in cycle t presents the index on mem_addr in cycle t+1. The bridge captures mem_rdata at the end of cycle t+2. In cycle t+3 req_rdata holds that SRAM word and req_done pulses.
- R5: In read-only mode a write completes with req_done in cycle t+1, mem_wen stays 0 and the SRAM contents do not change. Reads follow R4.
- R6: In write-only mode a read completes with req_done in cycle t+1 and req_rdata = 0, and the SRAM is not read. Writes follow R3.
- R7: A request that arrives while a read sequence (cycles t+1 and t+2 of R4) is in progress is ignored. It produces no write enable and no done pulse of its own.
- R8: After reset req_done = 0, mem_wen = 0, req_rdata = 0 and mem_addr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Host byte address |
| req_wdata | input | 32 | Host write data |
| req_strb | input | 4 | Host byte strobes |
| req_done | output | 1 | Completion pulse |
| req_rdata | output | 32 | Registered read data |
| mem_addr | output | IDX_W | SRAM element address |
| mem_wdata | output | 32 | SRAM write data |
| mem_wen | output | 4 | SRAM per-byte write enables |
| mem_rdata | input | 32 | SRAM read data, valid one cycle after the address |

## Verification
The bench drives one request stream into three instances: one read-write, one read-only and one write-only, each with its own modelled SRAM. The same access therefore shows how each mode handles it. Full-word writes to every element, followed by read-back from addresses whose low two bits vary, separate correct index decoding from wrap or offset mistakes. Partial and empty strobe patterns separate true byte-lane enables from whole-word writes. Addresses one word below and one word above the window find off-by-one errors in the range compare. A request placed back-to-back behind a read shows whether the in-flight sequence is protected.

// File: rtl/swb_pkg.sv
package swb_pkg;

  typedef enum logic [1:0] {
    SWB_RW = 2'd0,
    SWB_RO = 2'd1,
    SWB_WO = 2'd2
  } swb_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_WAIT = 2'd2
  } swb_state_e;

  function automatic bit mode_writes(swb_mode_e m);
    return m != SWB_RO;
  endfunction

  function automatic bit mode_reads(swb_mode_e m);
    return m != SWB_WO;
  endfunction

  // byte address inside [base, base + span)
  function automatic logic win_hit(logic [31:0] a, logic [31:0] base, logic [31:0] span);
    return (a >= base) && ((a - base) < span);
  endfunction

  // word index within the window
  function automatic logic [31:0] win_elem(logic [31:0] a, logic [31:0] base);
    return (a - base) >> 2;
  endfunction

endpackage

// File: rtl/swb_decode.sv
module swb_decode
  import swb_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_0100,
  parameter int          DEPTH     = 16,
  parameter int          IDX_W     = 4
) (
  input  logic [31:0]      addr,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  localparam logic [31:0] SPAN = 32'(DEPTH * 4);

  logic [31:0] elem_full;

  always_comb begin
    hit       = win_hit(addr, BASE_ADDR, SPAN);
    elem_full = win_elem(addr, BASE_ADDR);
    idx       = elem_full[IDX_W-1:0];
  end
endmodule

// File: rtl/swb_ctrl.sv
module swb_ctrl
  import swb_pkg::*;
#(
  parameter swb_mode_e MODE  = SWB_RW,
  parameter int        IDX_W = 4,
  parameter int        DW    = 32,
  parameter int        BW    = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             hit,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    req_wdata,
  input  logic [BW-1:0]    req_strb,
  input  logic [DW-1:0]    mem_rdata,
  output logic             req_done,
  output logic [DW-1:0]    req_rdata,
  output logic [IDX_W-1:0] mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [BW-1:0]    mem_wen
);
  localparam bit WR_OK = mode_writes(MODE);
  localparam bit RD_OK = mode_reads(MODE);

  swb_state_e state;
  logic       idle;
  logic       accept;
  logic       wr_go;
  logic       rd_go;
  logic       blk_go;

  always_comb begin
    idle   = (state == ST_IDLE);
    accept = req_valid && hit && idle;
    wr_go  = accept && req_write && WR_OK;
    rd_go  = accept && !req_write && RD_OK;
    blk_go = accept && !wr_go && !rd_go;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wen   <= '0;
      req_done  <= 1'b0;
      req_rdata <= '0;
    end else begin
      mem_wen  <= wr_go ? req_strb : '0;
      req_done <= 1'b0;
      if (wr_go || rd_go) mem_addr <= idx;
      if (wr_go) begin
        mem_wdata <= req_wdata;
        req_done  <= 1'b1;
      end
      if (blk_go) begin
        req_done <= 1'b1;
        if (!req_write) req_rdata <= '0;
      end
      unique case (state)
        ST_IDLE: if (rd_go) state <= ST_ADDR;
        ST_ADDR: state <= ST_WAIT;
        ST_WAIT: begin
          req_rdata <= mem_rdata;
          req_done  <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit && idle) |=> (!req_done && mem_wen == '0));

  // R3
  wen_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wen != '0) |-> $past(req_valid && req_write && hit));

  // R3
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && hit && idle) |=> req_done);

  // R4
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |=> (req_done && req_rdata == $past(mem_rdata)));

  // R7
  rd_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT) |-> ($stable(mem_addr) && mem_wen == '0));

  generate
    if (MODE == SWB_RO) begin : g_ro_chk
      // R5
      ro_no_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wen == '0);
    end
    if (MODE == SWB_WO) begin : g_wo_chk
      // R6
      wo_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && hit && idle) |=> (req_done && req_rdata == '0));
    end
  endgenerate
endmodule

// File: rtl/sram_window_bridge.sv
module sram_window_bridge
  import swb_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR = 32'h0000_0100,
  parameter int          DEPTH     = 16,
  parameter swb_mode_e   MODE      = SWB_RW,
  parameter int          IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [31:0]      req_wdata,
  input  logic [3:0]       req_strb,
  output logic             req_done,
  output logic [31:0]      req_rdata,
  output logic [IDX_W-1:0] mem_addr,
  output logic [31:0]      mem_wdata,
  output logic [3:0]       mem_wen,
  input  logic [31:0]      mem_rdata
);
  logic             win_hit_w;
  logic [IDX_W-1:0] win_idx_w;

  swb_decode #(
    .BASE_ADDR(BASE_ADDR),
    .DEPTH    (DEPTH),
    .IDX_W    (IDX_W)
  ) u_dec (
    .addr(req_addr),
    .hit (win_hit_w),
    .idx (win_idx_w)
  );

  swb_ctrl #(
    .MODE (MODE),
    .IDX_W(IDX_W),
    .DW   (32)
  ) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .hit      (win_hit_w),
    .idx      (win_idx_w),
    .req_wdata(req_wdata),
    .req_strb (req_strb),
    .mem_rdata(mem_rdata),
    .req_done (req_done),
    .req_rdata(req_rdata),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_wen  (mem_wen)
  );
endmodule

// File: tb/sim_sram_window_bridge.sv
module sim_sram #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [3:0]    wen,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= {8'hA5, 16'h0000, 8'(k)};
      rdata <= '0;
    end else begin
      for (int b = 0; b < 4; b++)
        if (wen[b]) mem[addr][8*b +: 8] <= wdata[8*b +: 8];
      rdata <= mem[addr];
    end
  end
endmodule

module sim_sram_window_bridge;
  import swb_pkg::*;

  localparam logic [31:0] BASE = 32'h0000_0100;
  localparam int          DEP  = 16;

  typedef struct {
    int          issue;
    int          lat;
    bit          has_data;
    logic [31:0] data;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;

  logic        done0, done_ro, done_wo;
  logic [31:0] rdata0, rdata_ro, rdata_wo;
  logic [3:0]  addr0, addr_ro, addr_wo;
  logic [31:0] wdata0, wdata_ro, wdata_wo;
  logic [3:0]  wen0, wen_ro, wen_wo;
  logic [31:0] mr0, mr_ro, mr_wo;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  exp_t q[$];
  exp_t mon_e;
  logic [31:0] ref_rw [DEP];
  logic [31:0] ref_wo [DEP];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_window_bridge #(.BASE_ADDR(BASE), .DEPTH(DEP), .MODE(SWB_RW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .req_done(done0), .req_rdata(rdata0), .mem_addr(addr0),
    .mem_wdata(wdata0), .mem_wen(wen0), .mem_rdata(mr0));
  sim_sram #(.DEPTH(DEP), .AW(4)) u_m0 (
    .clk(clk), .rst_n(rst_n), .addr(addr0), .wdata(wdata0), .wen(wen0), .rdata(mr0));

  sram_window_bridge #(.BASE_ADDR(BASE), .DEPTH(DEP), .MODE(SWB_RO)) u_ro (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .req_done(done_ro), .req_rdata(rdata_ro), .mem_addr(addr_ro),
    .mem_wdata(wdata_ro), .mem_wen(wen_ro), .mem_rdata(mr_ro));
  sim_sram #(.DEPTH(DEP), .AW(4)) u_mro (
    .clk(clk), .rst_n(rst_n), .addr(addr_ro), .wdata(wdata_ro), .wen(wen_ro), .rdata(mr_ro));

  sram_window_bridge #(.BASE_ADDR(BASE), .DEPTH(DEP), .MODE(SWB_WO)) u_wo (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .req_done(done_wo), .req_rdata(rdata_wo), .mem_addr(addr_wo),
    .mem_wdata(wdata_wo), .mem_wen(wen_wo), .mem_rdata(mr_wo));
  sim_sram #(.DEPTH(DEP), .AW(4)) u_mwo (
    .clk(clk), .rst_n(rst_n), .addr(addr_wo), .wdata(wdata_wo), .wen(wen_wo), .rdata(mr_wo));

  function automatic logic [31:0] init_word(int k);
    return 32'hA500_0000 + 32'(k);
  endfunction

  function automatic bit in_win(logic [31:0] a);
    return (a >= BASE) && (a <= BASE + 32'(4 * DEP - 1));
  endfunction

  function automatic int word_of(logic [31:0] a);
    return int'((a - BASE) / 4);
  endfunction

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] s);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor for the read-write instance
  always @(negedge clk) begin
    if (rst_n && done0) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected done", 32'd1, 32'd0);
      end else begin
        mon_e = q.pop_front();
        chk(cyc - mon_e.issue == mon_e.lat, {mon_e.tag, " latency"},
            32'(cyc - mon_e.issue), 32'(mon_e.lat));
        if (mon_e.has_data) chk(rdata0 == mon_e.data, {mon_e.tag, " data"}, rdata0, mon_e.data);
      end
    end
  end

  task automatic issue(input bit wr, input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    bit          hit = in_win(a);
    int          idx = hit ? word_of(a) : 0;
    int          l0 = 0, lro = 0, lwo = 0;
    logic [31:0] dro = '0, dwo = '0;
    exp_t        e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_strb = s;
    if (hit) begin
      e.issue = cyc; e.lat = wr ? 1 : 3; e.has_data = !wr;
      e.data = ref_rw[idx]; e.tag = wr ? "R3" : "R4";
      q.push_back(e);
    end
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        if (hit && wr) begin
          chk(wen0 == s, "R3 wen", 32'(wen0), 32'(s));
          chk(32'(addr0) == 32'(idx), "R3 addr", 32'(addr0), 32'(idx));
          chk(wdata0 == d, "R3 wdata", wdata0, d);
          chk(wen_ro == 4'h0, "R5 wen", 32'(wen_ro), 32'h0);
        end else if (hit) begin
          chk(32'(addr0) == 32'(idx), "R4 addr", 32'(addr0), 32'(idx));
          chk(wen0 == 4'h0, "R4 wen", 32'(wen0), 32'h0);
        end else begin
          chk((wen0 | wen_ro | wen_wo) == 4'h0, "R2 wen", 32'(wen0 | wen_ro | wen_wo), 32'h0);
        end
      end
      if (k == 2 && hit && wr) chk(wen0 == 4'h0, "R3 wen single", 32'(wen0), 32'h0);
      if (done0 && l0 == 0) l0 = k;
      if (done_ro && lro == 0) begin lro = k; dro = rdata_ro; end
      if (done_wo && lwo == 0) begin lwo = k; dwo = rdata_wo; end
    end
    if (!hit) begin
      chk(l0 == 0 && lro == 0 && lwo == 0, "R2 done", 32'(l0 + lro + lwo), 32'h0);
    end else begin
      chk(lro == (wr ? 1 : 3), "R5 latency", 32'(lro), wr ? 32'd1 : 32'd3);
      if (!wr) chk(dro == init_word(idx), "R5 data", dro, init_word(idx));
      chk(lwo == 1, "R6 latency", 32'(lwo), 32'd1);
      if (!wr) chk(dwo == 32'h0, "R6 data", dwo, 32'h0);
      if (wr) begin
        ref_rw[idx] = merge(ref_rw[idx], d, s);
        ref_wo[idx] = merge(ref_wo[idx], d, s);
      end
    end
  endtask

  // read followed at once by a write to the same word
  task automatic overlap(input int idx, input logic [31:0] d);
    exp_t e;
    bit   saw_wen = 1'b0;
    int   dones = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = BASE + 32'(4 * idx); req_strb = 4'hF;
    e.issue = cyc; e.lat = 3; e.has_data = 1'b1; e.data = ref_rw[idx]; e.tag = "R4";
    q.push_back(e);
    @(negedge clk);
    req_write = 1'b1; req_wdata = d;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (wen0 != 4'h0) saw_wen = 1'b1;
      if (done0) dones++;
    end
    chk(!saw_wen, "R7 wen", 32'(saw_wen), 32'h0);
    chk(dones == 1, "R7 done count", 32'(dones), 32'd1);
    ref_wo[idx] = d;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "watchdog", 32'(cyc), 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int k = 0; k < DEP; k++) begin
      ref_rw[k] = init_word(k);
      ref_wo[k] = init_word(k);
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done0 == 1'b0, "R8 done", 32'(done0), 32'h0);
    chk(wen0 == 4'h0, "R8 wen", 32'(wen0), 32'h0);
    chk(rdata0 == 32'h0, "R8 rdata", rdata0, 32'h0);
    chk(addr0 == 4'h0, "R8 addr", 32'(addr0), 32'h0);

    // R3 full-word writes to every element
    for (int k = 0; k < DEP; k++)
      issue(1'b1, BASE + 32'(4 * k), {16'hC0DE, 8'(k), 8'(~k)}, 4'hF);
    // R3 byte lanes, low address bits ignored (R1)
    issue(1'b1, BASE + 32'h16, 32'hFFFF_FFFF, 4'b0101);
    issue(1'b1, BASE + 32'h1C, 32'h1234_5678, 4'b0000);
    issue(1'b1, BASE + 32'h3D, 32'h8800_0000, 4'b1000);
    // R4 read back, R1 offsets inside a word
    for (int k = 0; k < DEP; k++)
      issue(1'b0, BASE + 32'(4 * k) + 32'(k % 4), 32'h0, 4'h0);
    // R2 just outside both window edges and far away
    issue(1'b0, BASE - 32'd4, 32'h0, 4'h0);
    issue(1'b1, BASE + 32'(4 * DEP), 32'hDEAD_BEEF, 4'hF);
    issue(1'b0, 32'h0000_0000, 32'h0, 4'h0);
    issue(1'b1, 32'hFFFF_FFFC, 32'hDEAD_BEEF, 4'hF);
    // R7 request behind an in-flight read
    overlap(9, 32'h5555_AAAA);
    issue(1'b0, BASE + 32'h24, 32'h0, 4'h0);
    issue(1'b0, BASE + 32'h3C, 32'h0, 4'h0);

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R4 missing done", 32'(q.size()), 32'h0);
    for (int k = 0; k < DEP; k++) begin
      chk(u_mwo.mem[k] == ref_wo[k], "R6 sram content", u_mwo.mem[k], ref_wo[k]);
      chk(u_mro.mem[k] == init_word(k), "R5 sram content", u_mro.mem[k], init_word(k));
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule